// File: doc/BRIEF.md
# Doorbell to Interrupt-Message Write Translator

This block sits behind the doorbell part of a host's shared doorbell and memory-window aperture. Every inbound write that lands there rings one doorbell, and the block turns it into one outbound interrupt-message write aimed at the peer host. The doorbell number is the write offset shifted right by the base-2 log of the doorbell entry size. The outbound write carries the target address and the 32-bit data word programmed for that doorbell.

Each doorbell has its own slot in the configuration table. In single-address mode every doorbell uses the address in slot 0. In per-vector mode each doorbell uses the address in its own slot. So a host that gives one message address for all vectors and a host that gives a separate address per vector both use the same path. Writes are refused until the doorbell setup has completed. Writes past the configured doorbell count are dropped and counted.

Both data interfaces are valid/ready. An inbound write is taken on a cycle where `in_valid` and `in_ready` are both high. An outbound message is handed over on a cycle where `out_valid` and `out_ready` are both high. The block holds at most one pending message. `in_ready` is high when no message is pending or when the pending one is being handed over in the same cycle. While the outbound side stalls, `out_valid` stays high and the address and data do not change.

Top module: `db_msi_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, `err_count` is 0 and `in_ready` is 1.
- R2: For an accepted write with `in_offset` below `cfg_mw1_offset`, the doorbell index is `in_offset >> cfg_entry_log2`. The outbound data is the word in slot `index` of `cfg_db_data`; slot k occupies bits [32k+31:32k].
- R3: When `cfg_per_vector` is 0, the outbound address of every doorbell is slot 0 of `cfg_db_addr`; slot k occupies bits [64k+63:64k].
- R4: When `cfg_per_vector` is 1, the outbound address is slot `index` of `cfg_db_addr`.
- R5: While `cfg_db_ready` is 0, an accepted doorbell-area write produces no outbound write and increments `err_count` by one.
- R6: An accepted doorbell-area write whose index is at or above `min(cfg_db_count, NUM_DB)` produces no outbound write and increments `err_count` by one. Index `cfg_db_count-1` is still delivered.
- R7: An accepted write with `in_offset` at or above `cfg_mw1_offset` produces no outbound write and leaves `err_count` unchanged.
- R8: The value of `in_data` has no effect on the outbound address or data.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_data` hold, and `in_ready` is 0.
- R10: A delivered write raises `out_valid` in the cycle after it is accepted. With `out_ready` held at 1, one write per cycle passes with none lost.
- R11: `err_count` saturates at its maximum value (255 by default) and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_db_ready | input | 1 | Doorbell setup has completed |
| cfg_per_vector | input | 1 | 1: per-doorbell address, 0: shared address in slot 0 |
| cfg_db_count | input | CNT_W (6) | Number of active doorbells |
| cfg_entry_log2 | input | 5 | Base-2 log of the doorbell entry size in bytes |
| cfg_mw1_offset | input | OFF_W (16) | Offset where memory window 1 starts |
| cfg_db_addr | input | NUM_DB*64 | Flattened per-doorbell target addresses |
| cfg_db_data | input | NUM_DB*32 | Flattened per-doorbell data words |
| in_valid | input | 1 | Inbound write valid |
| in_ready | output | 1 | Inbound write ready |
| in_offset | input | OFF_W (16) | Byte offset of the write in the aperture |
| in_data | input | 32 | Data written by the host (ignored) |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound message ready |
| out_addr | output | 64 | Outbound message address |
| out_data | output | 32 | Outbound message data |
| err_count | output | ERR_W (8) | Saturating count of refused doorbell writes |

## Verification
Two functions can meet in the same clock edge: the pending message is handed over, and a new inbound write is accepted into the slot being freed. The bench provokes this by stalling the outbound side with one message pending and holding a second write on the inbound side. It checks that `in_ready` stays low and the first message stays unchanged. It then raises `out_ready` and checks that the second message replaces the first on the very next cycle with its own address and data. Back-to-back writes with the outbound side always ready exercise the same edge on every cycle.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int MSG_ADDR_W = 64;
  localparam int MSG_DATA_W = 32;

  typedef struct packed {
    logic [MSG_ADDR_W-1:0] addr;
    logic [MSG_DATA_W-1:0] data;
  } db_msg_t;
endpackage

// File: rtl/db_decode.sv
module db_decode #(
  parameter int OFF_W  = 16,
  parameter int NUM_DB = 32,
  parameter int CNT_W  = $clog2(NUM_DB + 1),
  parameter int IDX_W  = $clog2(NUM_DB)
) (
  input  logic             cfg_db_ready,
  input  logic [CNT_W-1:0] cfg_db_count,
  input  logic [4:0]       cfg_entry_log2,
  input  logic [OFF_W-1:0] cfg_mw1_offset,
  input  logic [OFF_W-1:0] offset,
  output logic             in_window,
  output logic             hit,
  output logic [IDX_W-1:0] index
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_DB);

  logic [OFF_W-1:0] idx_full;
  logic [CNT_W-1:0] eff_count;

  always_comb begin
    in_window = offset >= cfg_mw1_offset;
    idx_full  = offset >> cfg_entry_log2;
    eff_count = (cfg_db_count > MAX_CNT) ? MAX_CNT : cfg_db_count;
    index     = idx_full[IDX_W-1:0];
    hit       = cfg_db_ready && !in_window &&
                (idx_full < OFF_W'(eff_count));
  end
endmodule

// File: rtl/db_lut.sv
module db_lut
  import db_pkg::*;
#(
  parameter int NUM_DB = 32,
  parameter int IDX_W  = $clog2(NUM_DB)
) (
  input  logic [NUM_DB*MSG_ADDR_W-1:0] tbl_addr,
  input  logic [NUM_DB*MSG_DATA_W-1:0] tbl_data,
  input  logic                         per_vector,
  input  logic [IDX_W-1:0]             index,
  output db_msg_t                      msg
);
  logic [MSG_ADDR_W-1:0] addr_arr [NUM_DB];
  logic [MSG_DATA_W-1:0] data_arr [NUM_DB];

  for (genvar g = 0; g < NUM_DB; g++) begin : g_slot
    assign addr_arr[g] = tbl_addr[g*MSG_ADDR_W +: MSG_ADDR_W];
    assign data_arr[g] = tbl_data[g*MSG_DATA_W +: MSG_DATA_W];
  end

  always_comb begin
    msg.addr = per_vector ? addr_arr[index] : addr_arr[0];
    msg.data = data_arr[index];
  end
endmodule

// File: rtl/db_err_cnt.sv
module db_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (bump && count != TOP) count <= count + W'(1);
  end
endmodule

// File: rtl/db_msi_xlate.sv
module db_msi_xlate
  import db_pkg::*;
#(
  parameter int NUM_DB = 32,
  parameter int OFF_W  = 16,
  parameter int ERR_W  = 8,
  parameter int CNT_W  = $clog2(NUM_DB + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_db_ready,
  input  logic                         cfg_per_vector,
  input  logic [CNT_W-1:0]             cfg_db_count,
  input  logic [4:0]                   cfg_entry_log2,
  input  logic [OFF_W-1:0]             cfg_mw1_offset,
  input  logic [NUM_DB*MSG_ADDR_W-1:0] cfg_db_addr,
  input  logic [NUM_DB*MSG_DATA_W-1:0] cfg_db_data,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [OFF_W-1:0]             in_offset,
  input  logic [MSG_DATA_W-1:0]        in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [MSG_ADDR_W-1:0]        out_addr,
  output logic [MSG_DATA_W-1:0]        out_data,
  output logic [ERR_W-1:0]             err_count
);
  localparam int IDX_W = $clog2(NUM_DB);

  logic             in_window, hit, accept;
  logic [IDX_W-1:0] index;
  db_msg_t          lut_msg, pend_msg;
  logic             unused_wdata;

  assign unused_wdata = ^in_data;

  db_decode #(.OFF_W(OFF_W), .NUM_DB(NUM_DB), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dec (
    .cfg_db_ready  (cfg_db_ready),
    .cfg_db_count  (cfg_db_count),
    .cfg_entry_log2(cfg_entry_log2),
    .cfg_mw1_offset(cfg_mw1_offset),
    .offset        (in_offset),
    .in_window     (in_window),
    .hit           (hit),
    .index         (index)
  );

  db_lut #(.NUM_DB(NUM_DB), .IDX_W(IDX_W)) u_lut (
    .tbl_addr  (cfg_db_addr),
    .tbl_data  (cfg_db_data),
    .per_vector(cfg_per_vector),
    .index     (index),
    .msg       (lut_msg)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pend_msg  <= '0;
    end else if (in_ready) begin
      out_valid <= accept && hit;
      if (accept && hit) pend_msg <= lut_msg;
    end
  end

  assign out_addr = pend_msg.addr;
  assign out_data = pend_msg.data;

  db_err_cnt #(.W(ERR_W)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (accept && !in_window && !hit),
    .count(err_count)
  );
endmodule

// File: rtl/db_msi_xlate_chk.sv
module db_msi_xlate_chk #(
  parameter int OFF_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_db_ready,
  input logic [OFF_W-1:0] cfg_mw1_offset,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OFF_W-1:0] in_offset,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_addr,
  input logic [31:0]      out_data,
  input logic [ERR_W-1:0] err_count
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)); // R9

  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_NO_OUT_UNCONF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_db_ready |=> !out_valid); // R5

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + ERR_W'(1))); // R11

  AST_WINDOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_offset >= cfg_mw1_offset
      |=> !out_valid && err_count == $past(err_count)); // R7
endmodule

bind db_msi_xlate db_msi_xlate_chk #(.OFF_W(OFF_W), .ERR_W(ERR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_db_ready  (cfg_db_ready),
  .cfg_mw1_offset(cfg_mw1_offset),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_offset     (in_offset),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_data      (out_data),
  .err_count     (err_count)
);

// File: tb/tb_db_msi_xlate.sv
module tb_db_msi_xlate;
  localparam int NUM_DB = 32;
  localparam int OFF_W  = 16;
  localparam int ERR_W  = 8;
  localparam int CNT_W  = $clog2(NUM_DB + 1);

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    cfg_db_ready = 1'b0;
  logic                    cfg_per_vector = 1'b0;
  logic [CNT_W-1:0]        cfg_db_count = '0;
  logic [4:0]              cfg_entry_log2 = 5'd2;
  logic [OFF_W-1:0]        cfg_mw1_offset = 16'h0100;
  logic [NUM_DB*64-1:0]    cfg_db_addr;
  logic [NUM_DB*32-1:0]    cfg_db_data;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [OFF_W-1:0]        in_offset = '0;
  logic [31:0]             in_data = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b1;
  logic [63:0]             out_addr;
  logic [31:0]             out_data;
  logic [ERR_W-1:0]        err_count;

  int checks = 0;
  int errors = 0;
  int exp_err = 0;

  always #2.5 clk = ~clk;

  db_msi_xlate #(.NUM_DB(NUM_DB), .OFF_W(OFF_W), .ERR_W(ERR_W)) dut (.*);

  function automatic logic [63:0] slot_addr(int k);
    return 64'hFEE0_0000_0000_0000 + 64'(k) * 64'h40 + 64'h8;
  endfunction

  function automatic logic [31:0] slot_data(int k);
    return 32'hA5C0_0000 + 32'(k) * 32'h11;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [OFF_W-1:0] off, logic [31:0] wd);
    @(negedge clk);
    in_valid  = 1'b1;
    in_offset = off;
    in_data   = wd;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_msg(string req, int idx, int addr_slot);
    @(negedge clk);
    check(req, "out_valid", 64'(out_valid), 64'd1);
    check(req, "out_addr", out_addr, slot_addr(addr_slot));
    check(req, "out_data", 64'(out_data), 64'(slot_data(idx)));
  endtask

  task automatic expect_drop(string req);
    @(negedge clk);
    check(req, "out_valid", 64'(out_valid), 64'd0);
    check(req, "err_count", 64'(err_count), 64'(exp_err));
  endtask

  task automatic t_reset;
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "err_count", 64'(err_count), 64'd0);
    check("R1", "in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_unconfigured;
    send(16'h0008, 32'h1);
    exp_err++;
    expect_drop("R5");
  endtask

  task automatic t_shared_addr;
    cfg_db_ready = 1'b1; cfg_db_count = 6'd8; cfg_per_vector = 1'b0;
    send(16'h000C, 32'h0);           // index 3
    expect_msg("R3", 3, 0);
    send(16'h001C, 32'h0);           // index 7, last active: R6 boundary
    expect_msg("R6", 7, 0);
  endtask

  task automatic t_per_vector;
    cfg_per_vector = 1'b1;
    send(16'h0014, 32'h0);           // index 5
    expect_msg("R4", 5, 5);
    cfg_entry_log2 = 5'd3;
    send(16'h0038, 32'h0);           // 0x38 >> 3 = index 7
    expect_msg("R2", 7, 7);
    cfg_entry_log2 = 5'd2;
  endtask

  task automatic t_over_count;
    send(16'h0020, 32'h0);           // index 8 with count 8
    exp_err++;
    expect_drop("R6");
    cfg_db_count = 6'd40;            // clamps to NUM_DB; index 32 refused
    send(16'h0080, 32'h0);
    exp_err++;
    expect_drop("R6");
    cfg_db_count = 6'd8;
  endtask

  task automatic t_window;
    send(16'h0100, 32'h0);
    expect_drop("R7");
    send(16'h01F0, 32'h0);
    expect_drop("R7");
  endtask

  task automatic t_data_ignored;
    send(16'h0008, 32'hFFFF_FFFF);
    expect_msg("R8", 2, 2);
    send(16'h0008, 32'h1234_5678);
    expect_msg("R8", 2, 2);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    send(16'h0004, 32'h0);           // index 1 pending
    @(negedge clk);
    in_valid = 1'b1; in_offset = 16'h0018;  // index 6 waiting
    check("R9", "in_ready", 64'(in_ready), 64'd0);
    @(negedge clk);
    check("R9", "out_valid", 64'(out_valid), 64'd1);
    check("R9", "out_data", 64'(out_data), 64'(slot_data(1)));
    check("R9", "in_ready", 64'(in_ready), 64'd0);
    out_ready = 1'b1;                // handover and refill on same edge
    @(posedge clk);
    #1 in_valid = 1'b0;
    expect_msg("R10", 6, 6);
    @(negedge clk);
    check("R10", "out_valid after drain", 64'(out_valid), 64'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_offset = 16'h0000;
    @(negedge clk);
    check("R10", "first out_data", 64'(out_data), 64'(slot_data(0)));
    in_offset = 16'h0010;
    @(negedge clk);
    check("R10", "second out_data", 64'(out_data), 64'(slot_data(4)));
    check("R10", "second out_valid", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_saturate;
    @(negedge clk);
    in_valid = 1'b1; in_offset = 16'h0040;  // index 16, over count
    for (int i = 0; i < 300; i++) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11", "err_count saturated", 64'(err_count), 64'd255);
    check("R11", "out_valid", 64'(out_valid), 64'd0);
  endtask

  initial begin
    for (int k = 0; k < NUM_DB; k++) begin
      cfg_db_addr[k*64 +: 64] = slot_addr(k);
      cfg_db_data[k*32 +: 32] = slot_data(k);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unconfigured();
    t_shared_addr();
    t_per_vector();
    t_over_count();
    t_window();
    t_data_ignored();
    t_backpressure();
    t_back_to_back();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule